// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Model

This block is a synthesizable behavioural model of a dynamic memory whose row and column addresses share one narrow bus. A falling row strobe captures the row number and moves the whole row into a row buffer. The stored copy is then cleared, which models the destructive read. Each falling column strobe that follows picks one bit of that buffer. With the write enable low, the bit is overwritten from the data input. With it high, the bit is driven out while the column strobe stays low. A rising row strobe writes the buffer back into the array.

A refresh request runs an internal restore of the next row in a wrapping sequence. The restore is a destructive read followed by a write-back. It is acknowledged by a one-cycle pulse. A request that arrives while a row is open waits until the row strobe has been high for two samples.

All strobes are sampled on the system clock, and edges are found by comparing a strobe with its previous sample. The tri-stated data output appears as a data bit plus an output-enable flag. The data bit is 0 whenever the enable is low.

Top module: `dram_mux_core`

## Requirements
- R1: After reset every stored bit is 0, `rdata_oe` is 0, `rdata` is 0 and `rfsh_ack` is 0.
- R2: The clock edge that first sees `row_strobe_n` low, after seeing it high, opens the row given by `mux_addr`. Later changes of `mux_addr` do not change which row is open.
- R3: When a row is open, the edge that first sees `col_strobe_n` low with `wr_en_n` high latches the column from `mux_addr`. From the next cycle, `rdata_oe` is 1 and `rdata` is the addressed bit. Both hold while the column strobe stays low, even if `mux_addr` changes.
- R4: A column strobe fall that sees `wr_en_n` low replaces the addressed bit of the open row with `wdata`. `rdata_oe` stays 0 during such a write.
- R5: The edge that sees `row_strobe_n` high again writes the row buffer back. A later access to the same row returns the written bits, and all other bits are unchanged.
- R6: While the row strobe stays low, any number of column strobe pulses read and write bits of the open row without reopening it.
- R7: A column strobe fall while no row is open has no effect: no output is enabled and no bit is changed.
- R8: With no row open, a `rfsh_req` pulse sampled at clock edge k gives a single-cycle `rfsh_ack` after edge k+1. Refreshing every row leaves all stored data unchanged.
- R9: A refresh request made while a row is open is held. The refresh starts at the second edge that sees `row_strobe_n` high, and `rfsh_ack` follows one edge later.
- R10: `rdata_oe` drops to 0 at the edge that sees the row strobe high, even if the column strobe is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_strobe_n | input | 1 | Active-low row strobe |
| col_strobe_n | input | 1 | Active-low column strobe |
| wr_en_n | input | 1 | Active-low write enable, sampled at the column strobe fall |
| mux_addr | input | AW (6) | Shared row/column address bus |
| wdata | input | 1 | Write data bit |
| rdata | output | 1 | Read data bit, 0 when not enabled |
| rdata_oe | output | 1 | Output enable standing in for the tri-state driver |
| rfsh_req | input | 1 | Refresh request pulse |
| rfsh_ack | output | 1 | One-cycle pulse when a refresh has completed |

## Verification
The bench moves `mux_addr` right after each strobe fall. A design that re-read the bus instead of latching it would return the wrong row or bit. Page-mode pulses under a single row strobe, and a row strobe rise while the column strobe is still low, catch designs that reopen the row or leave the output driven. A column strobe with write enable low but no open row must leave the stored data untouched. Refresh runs over every row and is then read back; a restore that lost the cleared copy would show up as zeros. A request made during an open row must not be acknowledged until the exact cycle after the close.

// File: rtl/dram_mux_pkg.sv
package dram_mux_pkg;
   typedef enum logic [0:0] {
      RF_IDLE    = 1'b0,
      RF_RESTORE = 1'b1
   } rf_phase_e;

   function automatic bit is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/dram_strobe_edge.sv
module dram_strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic level_q,
   output logic fell,
   output logic rose
);
   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= strobe_n;
   end

   assign fell = level_q & ~strobe_n;
   assign rose = ~level_q & strobe_n;
endmodule

// File: rtl/dram_row_store.sv
module dram_row_store #(
   parameter int ROWS = 64,
   parameter int COLS = 64,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [RW-1:0]   open_row,
   output logic [COLS-1:0] open_data,
   input  logic            open_clr,
   input  logic [RW-1:0]   close_row,
   input  logic [COLS-1:0] close_data,
   input  logic            close_wb,
   input  logic [RW-1:0]   rf_row,
   output logic [COLS-1:0] rf_data,
   input  logic            rf_clr,
   input  logic            rf_wb,
   input  logic [COLS-1:0] rf_wb_data
);
   logic [COLS-1:0] rows_w [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      logic [COLS-1:0] bits_q;
      logic            hit_open, hit_close, hit_rf;

      assign hit_open  = open_clr && (open_row  == RW'(r));
      assign hit_close = close_wb && (close_row == RW'(r));
      assign hit_rf    = (rf_row == RW'(r));

      always_ff @(posedge clk) begin
         if (!rst_n)                bits_q <= '0;
         else if (hit_open)         bits_q <= '0;
         else if (hit_close)        bits_q <= close_data;
         else if (rf_clr && hit_rf) bits_q <= '0;
         else if (rf_wb && hit_rf)  bits_q <= rf_wb_data;
      end

      assign rows_w[r] = bits_q;
   end

   assign open_data = rows_w[open_row];
   assign rf_data   = rows_w[rf_row];
endmodule

// File: rtl/dram_refresh_ctl.sv
module dram_refresh_ctl
   import dram_mux_pkg::*;
#(
   parameter int ROWS = 64,
   parameter int COLS = 64,
   localparam int RW  = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            ras_idle,
   input  logic [COLS-1:0] row_data,
   output logic [RW-1:0]   row_sel,
   output logic            clr_en,
   output logic            wb_en,
   output logic [COLS-1:0] hold_data,
   output logic            ack
);
   rf_phase_e       phase_q;
   logic            pend_q;
   logic [RW-1:0]   ctr_q;
   logic [COLS-1:0] hold_q;
   logic            ack_q;
   logic            want;

   assign want      = pend_q | req;
   assign clr_en    = (phase_q == RF_IDLE) && want && ras_idle;
   assign wb_en     = (phase_q == RF_RESTORE);
   assign row_sel   = ctr_q;
   assign hold_data = hold_q;
   assign ack       = ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= RF_IDLE;
         pend_q  <= 1'b0;
         ctr_q   <= '0;
         hold_q  <= '0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (phase_q)
            RF_IDLE: begin
               if (clr_en) begin
                  hold_q  <= row_data;
                  phase_q <= RF_RESTORE;
                  pend_q  <= 1'b0;
               end else begin
                  pend_q <= want;
               end
            end
            RF_RESTORE: begin
               phase_q <= RF_IDLE;
               ack_q   <= 1'b1;
               ctr_q   <= ctr_q + 1'b1;
               pend_q  <= want;
            end
            default: phase_q <= RF_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dram_mux_core.sv
module dram_mux_core
   import dram_mux_pkg::*;
#(
   parameter int ROWS = 64,
   parameter int COLS = 64,
   parameter int AW   = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          row_strobe_n,
   input  logic          col_strobe_n,
   input  logic          wr_en_n,
   input  logic [AW-1:0] mux_addr,
   input  logic          wdata,
   output logic          rdata,
   output logic          rdata_oe,
   input  logic          rfsh_req,
   output logic          rfsh_ack
);
   localparam int RW = $clog2(ROWS);
   localparam int CW = $clog2(COLS);

   if (!is_pow2(ROWS) || !is_pow2(COLS)) begin : g_bad_geom
      $error("ROWS and COLS must be powers of two, at least 2");
   end
   if (AW < RW || AW < CW) begin : g_bad_aw
      $error("AW too narrow for row or column index");
   end

   logic ras_q, ras_fell, ras_rose;
   logic cas_q, cas_fell, cas_rose;

   dram_strobe_edge u_ras_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n(row_strobe_n),
      .level_q(ras_q), .fell(ras_fell), .rose(ras_rose));

   dram_strobe_edge u_cas_edge (
      .clk(clk), .rst_n(rst_n), .strobe_n(col_strobe_n),
      .level_q(cas_q), .fell(cas_fell), .rose(cas_rose));

   logic            row_open_q;
   logic [RW-1:0]   row_q;
   logic [CW-1:0]   col_q;
   logic [COLS-1:0] buf_q;
   logic            rd_act_q;

   logic            open_ev, close_ev, col_ev;
   logic [RW-1:0]   addr_row;
   logic [CW-1:0]   addr_col;
   logic [COLS-1:0] arr_open_data, open_fill;
   logic [RW-1:0]   rf_row;
   logic [COLS-1:0] rf_rd_data, rf_hold;
   logic            rf_clr, rf_wb;

   assign addr_row = mux_addr[RW-1:0];
   assign addr_col = mux_addr[CW-1:0];
   assign open_ev  = ras_fell;
   assign close_ev = ras_rose & row_open_q;
   assign col_ev   = cas_fell & row_open_q & ~row_strobe_n;

   // a row being restored by refresh in this cycle is taken from the hold copy
   assign open_fill = (rf_wb && (rf_row == addr_row)) ? rf_hold : arr_open_data;

   dram_row_store #(.ROWS(ROWS), .COLS(COLS)) u_store (
      .clk(clk), .rst_n(rst_n),
      .open_row(addr_row), .open_data(arr_open_data), .open_clr(open_ev),
      .close_row(row_q), .close_data(buf_q), .close_wb(close_ev),
      .rf_row(rf_row), .rf_data(rf_rd_data), .rf_clr(rf_clr),
      .rf_wb(rf_wb), .rf_wb_data(rf_hold));

   dram_refresh_ctl #(.ROWS(ROWS), .COLS(COLS)) u_rfsh (
      .clk(clk), .rst_n(rst_n), .req(rfsh_req),
      .ras_idle(row_strobe_n & ras_q & ~row_open_q),
      .row_data(rf_rd_data), .row_sel(rf_row),
      .clr_en(rf_clr), .wb_en(rf_wb), .hold_data(rf_hold), .ack(rfsh_ack));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_open_q <= 1'b0;
         row_q      <= '0;
         col_q      <= '0;
         buf_q      <= '0;
         rd_act_q   <= 1'b0;
      end else begin
         if (open_ev) begin
            row_q      <= addr_row;
            buf_q      <= open_fill;
            row_open_q <= 1'b1;
         end else if (close_ev) begin
            row_open_q <= 1'b0;
            rd_act_q   <= 1'b0;
         end else if (col_ev) begin
            col_q    <= addr_col;
            rd_act_q <= wr_en_n;
            if (!wr_en_n) buf_q[addr_col] <= wdata;
         end else if (cas_rose || row_strobe_n) begin
            rd_act_q <= 1'b0;
         end
      end
   end

   assign rdata_oe = rd_act_q;
   assign rdata    = rd_act_q & buf_q[col_q];
endmodule

// File: rtl/dram_mux_core_chk.sv
module dram_mux_core_chk (
   input logic clk,
   input logic rst_n,
   input logic row_strobe_n,
   input logic col_strobe_n,
   input logic rdata_oe,
   input logic rfsh_ack,
   input logic row_open_q
);
   // R3
   oe_needs_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(!col_strobe_n));

   // R10
   oe_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> $past(!row_strobe_n));

   // R7
   closed_cas_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(col_strobe_n) && !row_open_q) |=> !rdata_oe);

   // R8
   ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_ack |=> !rfsh_ack);

   // R9
   ack_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rfsh_ack |-> ($past(row_strobe_n, 2) && $past(row_strobe_n, 3)));
endmodule

bind dram_mux_core dram_mux_core_chk u_chk (
   .clk(clk), .rst_n(rst_n), .row_strobe_n(row_strobe_n),
   .col_strobe_n(col_strobe_n), .rdata_oe(rdata_oe),
   .rfsh_ack(rfsh_ack), .row_open_q(row_open_q));

// File: tb/dram_mux_core_bench.sv
module dram_mux_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [5:0] addr = '0;
   logic       wdata = 1'b0, rreq = 1'b0;
   logic       rdata, rdata_oe, rack;
   int         compared = 0, mismatched = 0;

   always #5 clk = ~clk;

   dram_mux_core u_dram_mux_core (
      .clk(clk), .rst_n(rst_n), .row_strobe_n(ras_n), .col_strobe_n(cas_n),
      .wr_en_n(we_n), .mux_addr(addr), .wdata(wdata), .rdata(rdata),
      .rdata_oe(rdata_oe), .rfsh_req(rreq), .rfsh_ack(rack));

   // {write, row[5:0], col[5:0], data-or-expected}
   localparam logic [13:0] VEC [14] = '{
      {1'b0, 6'd62, 6'd63, 1'b0},
      {1'b1, 6'd5,  6'd3,  1'b1},
      {1'b1, 6'd5,  6'd4,  1'b1},
      {1'b0, 6'd5,  6'd3,  1'b1},
      {1'b0, 6'd5,  6'd4,  1'b1},
      {1'b0, 6'd5,  6'd2,  1'b0},
      {1'b1, 6'd63, 6'd63, 1'b1},
      {1'b0, 6'd63, 6'd63, 1'b1},
      {1'b0, 6'd62, 6'd63, 1'b0},
      {1'b1, 6'd5,  6'd3,  1'b0},
      {1'b0, 6'd5,  6'd3,  1'b0},
      {1'b0, 6'd5,  6'd4,  1'b1},
      {1'b1, 6'd0,  6'd0,  1'b1},
      {1'b0, 6'd0,  6'd0,  1'b1}
   };

   task automatic step();
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic act, input logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   task automatic open_row(input int row);
      addr = 6'(row); ras_n = 1'b0; step();
   endtask

   task automatic close_row();
      cas_n = 1'b1; we_n = 1'b1; step();
      ras_n = 1'b1; step();
   endtask

   task automatic col_read(input int col, input logic exp, input string tag);
      addr = 6'(col); we_n = 1'b1; cas_n = 1'b0; step();
      addr = ~6'(col);
      chk({tag, " oe"}, rdata_oe, 1'b1);
      chk({tag, " data"}, rdata, exp);
      cas_n = 1'b1; step();
   endtask

   task automatic col_write(input int col, input logic d, input string tag);
      addr = 6'(col); we_n = 1'b0; wdata = d; cas_n = 1'b0; step();
      addr = ~6'(col); wdata = ~d;
      chk({tag, " oe during write"}, rdata_oe, 1'b0);
      cas_n = 1'b1; we_n = 1'b1; step();
   endtask

   initial begin
      #(150000 * 10);
      mismatched++;
      compared++;
      $display("FAIL R8 watchdog actual=timeout expected=completion");
      summary();
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1 oe", rdata_oe, 1'b0);
      chk("R1 data", rdata, 1'b0);
      chk("R1 ack", rack, 1'b0);

      // table walk: R3 reads, R4 writes, R5 persistence across close
      foreach (VEC[i]) begin
         open_row(int'(VEC[i][12:7]));
         if (VEC[i][13]) col_write(int'(VEC[i][6:1]), VEC[i][0], "R4");
         else            col_read(int'(VEC[i][6:1]), VEC[i][0], "R3/R5");
         close_row();
      end

      // R6 page mode and R2 row held while bus carries columns
      open_row(5);
      addr = 6'd9;
      col_read(3, 1'b0, "R6 page rd a");
      col_read(4, 1'b1, "R2 page rd b");
      col_write(7, 1'b1, "R6 page wr");
      col_read(7, 1'b1, "R6 page rd back");
      close_row();
      open_row(5);
      col_read(7, 1'b1, "R5 reopen");
      col_read(6, 1'b0, "R5 neighbour");
      close_row();

      // R7 column strobe with no open row
      addr = 6'd2; we_n = 1'b0; wdata = 1'b1; cas_n = 1'b0; step();
      chk("R7 oe closed", rdata_oe, 1'b0);
      step();
      chk("R7 oe closed hold", rdata_oe, 1'b0);
      cas_n = 1'b1; we_n = 1'b1; step();
      open_row(5);
      col_read(2, 1'b0, "R7 no write");
      close_row();

      // R10 row strobe rises with column strobe still low
      open_row(5);
      addr = 6'd4; cas_n = 1'b0; step();
      chk("R10 oe before", rdata_oe, 1'b1);
      ras_n = 1'b1; step();
      chk("R10 oe after ras rise", rdata_oe, 1'b0);
      cas_n = 1'b1; step();

      // R8 idle refresh timing
      rreq = 1'b1; step();
      rreq = 1'b0;
      chk("R8 ack early", rack, 1'b0);
      step();
      chk("R8 ack", rack, 1'b1);
      step();
      chk("R8 ack one cycle", rack, 1'b0);
      for (int n = 0; n < 70; n++) begin
         rreq = 1'b1; step(); rreq = 1'b0; step(); step();
      end
      open_row(5);
      col_read(4, 1'b1, "R8 data after refresh a");
      col_read(7, 1'b1, "R8 data after refresh b");
      close_row();
      open_row(63);
      col_read(63, 1'b1, "R8 data after refresh c");
      close_row();

      // R9 refresh deferred while a row is open
      step(); step();
      open_row(0);
      rreq = 1'b1; step(); rreq = 1'b0;
      for (int n = 0; n < 4; n++) begin
         chk("R9 held", rack, 1'b0);
         step();
      end
      ras_n = 1'b1; step();
      chk("R9 not yet at close", rack, 1'b0);
      step();
      chk("R9 not yet at start", rack, 1'b0);
      step();
      chk("R9 ack", rack, 1'b1);
      step();
      open_row(0);
      col_read(0, 1'b1, "R9 data kept");
      close_row();

      summary();
   end
endmodule